// File: doc/BRIEF.md
# Reduced-Complexity Wallace Tree Multiplier

This block multiplies two unsigned operands of a parameterised width `N` (default 8) and returns the full `2N`-bit product. It has no clock and no registers. The output follows the inputs after the combinational delay. It is meant to sit inside a datapath that supplies its own timing around it.

Every AND-term of the two operands is formed first. Within each weight column the terms are then packed toward row zero, so the upper-weight bits rise and the array takes an inverted-pyramid shape. A sequence of carry-save stages then compresses this array. Each stage cuts the rows into groups of three and puts a full adder on every complete group in every column. A two-bit remainder in a column gets a half adder only when that column would otherwise exceed the row target of the next stage. That target follows `r' = 2*floor(r/3) + r mod 3` from `r = N`, so the tree keeps the stage count of a classic Wallace reduction (four stages for `N = 8`) while using very few half adders. Lone bits and unpaired remainders go through a stage unchanged. Once at most two rows remain, a ripple-carry adder produces the product.

The layout of the whole tree is worked out at elaboration from `N`: column heights, adder counts per column and where the half adders go.

Top module: `wallace_rc_mult`

## Requirements
- R1: For every pair of unsigned `N`-bit operands, `product` equals the exact arithmetic product of `opa` and `opb`.
- R2: When either operand is zero, `product` is zero whatever the other operand holds.
- R3: With both operands at all ones, `product` equals `(2^N - 1)^2`, which sets bit `2N-1` and bit 0.
- R4: When one operand equals one, `product` equals the other operand zero-extended to `2N` bits.
- R5: When one operand is `2^k`, `product` equals the other operand shifted left by `k` places.
- R6: Swapping `opa` and `opb` leaves `product` unchanged.
- R7: With only bit `i` of `opa` and only bit `j` of `opb` set, `product` has exactly one bit set, at position `i+j`, for every `i` and `j`.
- R8: `product` is `2N` bits wide with no truncation, and the final two-row addition never produces a carry beyond bit `2N-1`.
- R9: The block is purely combinational: `product` tracks a change of either operand without any clock edge, including several changes within one clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | Unsigned multiplicand |
| opb | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned full-width product |

## Verification
Each column of the realigned array gets its own test. A walking single bit in each operand puts one AND-term at every (row, column) slot of the pyramid. A packing mistake that drops or misplaces a term shows up as a missing or shifted single output bit. The all-ones pair makes every column reach its full height and drives a carry chain through the top product bit. A dropped top-column carry or a too-narrow final adder would clear bit `2N-1`. Zero, one, power-of-two and swapped operands, followed by every operand pair at `N = 8`, catch half-adder placement errors that lose or duplicate a carry for only some values. Two operand changes within one clock period confirm that no hidden register delays the result.

// File: rtl/wtr_pkg.sv
package wtr_pkg;

    localparam int MAX_COLS   = 256;
    localparam int MAX_STAGES = 32;

    // selectors for tree_info
    localparam int INFO_HEIGHT = 0;
    localparam int INFO_HALF   = 1;
    localparam int INFO_STAGES = 2;

    // slots reserved per column in every level of the tree
    function automatic int slot_count(input int n);
        return n + 2;
    endfunction

    // AND-terms landing in weight column c of an n by n array
    function automatic int pp_height(input int n, input int c);
        if (c < 0 || c > 2 * n - 2) begin
            return 0;
        end
        return (c < n) ? c + 1 : 2 * n - 1 - c;
    endfunction

    // Plays the whole reduction at elaboration time.
    //   INFO_HEIGHT : bits in column col entering stage stg
    //   INFO_HALF   : half adders (0 or 1) placed in column col at stage stg
    //   INFO_STAGES : number of reduction stages
    function automatic int tree_info(input int n, input int stg, input int col, input int what);
        int h   [MAX_COLS];
        int nxt [MAX_COLS];
        int hac [MAX_COLS];
        int w;
        int r;
        int rn;
        int cin;
        int nfa;
        int rem;
        int nh;
        int st;
        w = 2 * n;
        for (int c = 0; c < MAX_COLS; c++) begin
            h[c]   = (c < w) ? pp_height(n, c) : 0;
            nxt[c] = 0;
            hac[c] = 0;
        end
        st = 0;
        r  = n;
        while (r > 2 && st < MAX_STAGES) begin
            if (what == INFO_HEIGHT && st == stg) begin
                return h[col];
            end
            rn  = 2 * (r / 3) + (r % 3);
            cin = 0;
            for (int c = 0; c < w; c++) begin
                nfa    = h[c] / 3;
                rem    = h[c] % 3;
                nh     = nfa + rem + cin;
                hac[c] = 0;
                if (nh > rn && rem == 2) begin
                    hac[c] = 1;
                    nh     = nh - 1;
                end
                nxt[c] = nh;
                cin    = nfa + hac[c];
            end
            if (what == INFO_HALF && st == stg) begin
                return hac[col];
            end
            r = 0;
            for (int c = 0; c < w; c++) begin
                h[c] = nxt[c];
                if (nxt[c] > r) begin
                    r = nxt[c];
                end
            end
            st = st + 1;
        end
        if (what == INFO_STAGES) begin
            return st;
        end
        if (what == INFO_HEIGHT) begin
            return h[col];
        end
        return 0;
    endfunction

endpackage

// File: rtl/wtr_cell.sv
module wtr_cell #(
    parameter bit FULL = 1'b1
) (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);

    generate
        if (FULL) begin : g_full
            assign s  = x ^ y ^ z;
            assign co = (x & y) | (z & (x ^ y));
        end else begin : g_half
            logic unused_z;
            assign unused_z = z;
            assign s  = x ^ y;
            assign co = x & y;
        end
    endgenerate

endmodule

// File: rtl/wtr_ppa.sv
module wtr_ppa
    import wtr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]                          a,
    input  logic [N-1:0]                          b,
    output logic [2*N-1:0][wtr_pkg::slot_count(N)-1:0] cols
);

    localparam int W    = 2 * N;
    localparam int HMAX = slot_count(N);

    // Terms of each column are packed from slot 0 upward: the high-weight
    // half of the array moves up, giving the inverted pyramid.
    generate
        for (genvar c = 0; c < W; c++) begin : g_col
            localparam int HC  = pp_height(N, c);
            localparam int ILO = (c > N - 1) ? c - N + 1 : 0;
            for (genvar k = 0; k < HMAX; k++) begin : g_slot
                if (k < HC) begin : g_term
                    assign cols[c][k] = a[ILO + k] & b[c - ILO - k];
                end else begin : g_empty
                    assign cols[c][k] = 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wtr_stage.sv
module wtr_stage
    import wtr_pkg::*;
#(
    parameter int N   = 8,
    parameter int STG = 0
) (
    input  logic [2*N-1:0][wtr_pkg::slot_count(N)-1:0] cols_in,
    output logic [2*N-1:0][wtr_pkg::slot_count(N)-1:0] cols_out
);

    localparam int W    = 2 * N;
    localparam int HMAX = slot_count(N);
    localparam int G    = HMAX / 3 + 1;

    logic [W-1:0][G-1:0] fa_s;
    logic [W-1:0][G-1:0] fa_c;
    logic [W-1:0]        ha_s;
    logic [W-1:0]        ha_c;

    generate
        for (genvar c = 0; c < W; c++) begin : g_col
            localparam int HC  = tree_info(N, STG, c, INFO_HEIGHT);
            localparam int NFA = HC / 3;
            localparam int REM = HC % 3;
            localparam int NHA = tree_info(N, STG, c, INFO_HALF);
            localparam int OWN = NFA + ((NHA != 0) ? 1 : REM);
            localparam int HP  = (c > 0) ? tree_info(N, STG, c - 1, INFO_HEIGHT) : 0;
            localparam int PFA = HP / 3;
            localparam int PHA = (c > 0) ? tree_info(N, STG, c - 1, INFO_HALF) : 0;
            localparam int CC  = PFA + PHA;

            // full adders on every complete group of three rows
            for (genvar g = 0; g < G; g++) begin : g_grp
                if (g < NFA) begin : g_fa
                    wtr_cell #(.FULL(1'b1)) u_fa (
                        .x (cols_in[c][3*g]),
                        .y (cols_in[c][3*g+1]),
                        .z (cols_in[c][3*g+2]),
                        .s (fa_s[c][g]),
                        .co(fa_c[c][g])
                    );
                end else begin : g_nofa
                    assign fa_s[c][g] = 1'b0;
                    assign fa_c[c][g] = 1'b0;
                end
            end

            // half adder only where the stage target demands it
            if (NHA != 0) begin : g_ha
                wtr_cell #(.FULL(1'b0)) u_ha (
                    .x (cols_in[c][3*NFA]),
                    .y (cols_in[c][3*NFA+1]),
                    .z (1'b0),
                    .s (ha_s[c]),
                    .co(ha_c[c])
                );
            end else begin : g_noha
                assign ha_s[c] = 1'b0;
                assign ha_c[c] = 1'b0;
            end

            // output packing: sums, passthrough remainder, carries from c-1
            for (genvar k = 0; k < HMAX; k++) begin : g_slot
                if (k < NFA) begin : g_sum
                    assign cols_out[c][k] = fa_s[c][k];
                end else if (k < OWN) begin : g_own
                    if (NHA != 0) begin : g_hs
                        assign cols_out[c][k] = ha_s[c];
                    end else begin : g_pass
                        assign cols_out[c][k] = cols_in[c][3*NFA + k - NFA];
                    end
                end else if (k < OWN + CC) begin : g_cin
                    if (k - OWN < PFA) begin : g_fc
                        assign cols_out[c][k] = fa_c[c-1][k-OWN];
                    end else begin : g_hc
                        assign cols_out[c][k] = ha_c[c-1];
                    end
                end else begin : g_zero
                    assign cols_out[c][k] = 1'b0;
                end
            end
        end
    endgenerate

    logic unused_sink;
    assign unused_sink = ^{cols_in, fa_s, fa_c, ha_s, ha_c};

    function automatic logic [W+7:0] weigh(input logic [W-1:0][HMAX-1:0] m);
        logic [W+7:0] acc;
        acc = '0;
        for (int c = 0; c < W; c++) begin
            for (int k = 0; k < HMAX; k++) begin
                acc = acc + ((W+8)'(m[c][k]) << c);
            end
        end
        return acc;
    endfunction

    always_comb begin
        AST_STAGE_KEEPS_VALUE: assert (weigh(cols_in) == weigh(cols_out)) else $error("stage %0d changed the array value", STG); // R1
    end

endmodule

// File: rtl/wtr_cpa.sv
module wtr_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);

    typedef struct packed {
        logic [W-1:0] sum_d;
        logic         carry_d;
    } add_t;

    add_t res_d;

    always_comb begin
        logic cy;
        cy = 1'b0;
        res_d = '0;
        for (int i = 0; i < W; i++) begin
            res_d.sum_d[i] = x[i] ^ y[i] ^ cy;
            cy = (x[i] & y[i]) | (cy & (x[i] ^ y[i]));
        end
        res_d.carry_d = cy;
    end

    assign sum = res_d.sum_d;

    always_comb begin
        AST_NO_OVERFLOW: assert (!res_d.carry_d) else $error("final adder carried past the product width"); // R8
    end

endmodule

// File: rtl/wallace_rc_mult.sv
module wallace_rc_mult
    import wtr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   opa,
    input  logic [N-1:0]   opb,
    output logic [2*N-1:0] product
);

    localparam int W    = 2 * N;
    localparam int HMAX = slot_count(N);
    localparam int S    = tree_info(N, 0, 0, INFO_STAGES);

    logic [W-1:0][HMAX-1:0] lvl [0:S];
    logic [W-1:0]           row0_d;
    logic [W-1:0]           row1_d;

    wtr_ppa #(.N(N)) u_ppa (
        .a   (opa),
        .b   (opb),
        .cols(lvl[0])
    );

    generate
        for (genvar s = 0; s < S; s++) begin : g_stage
            wtr_stage #(.N(N), .STG(s)) u_stage (
                .cols_in (lvl[s]),
                .cols_out(lvl[s+1])
            );
        end
        for (genvar c = 0; c < W; c++) begin : g_rows
            assign row0_d[c] = lvl[S][c][0];
            assign row1_d[c] = lvl[S][c][1];
        end
    endgenerate

    logic unused_top;
    assign unused_top = ^lvl[S];

    wtr_cpa #(.W(W)) u_cpa (
        .x  (row0_d),
        .y  (row1_d),
        .sum(product)
    );

    logic [W-1:0] ref_d;
    assign ref_d = {{N{1'b0}}, opa} * {{N{1'b0}}, opb};

    always_comb begin
        AST_PRODUCT_EXACT: assert (product == ref_d) else $error("product %0h expected %0h", product, ref_d); // R1
        AST_ZERO_OPERAND: assert (!((opa == '0) || (opb == '0)) || (product == '0)) else $error("zero operand gave %0h", product); // R2
        AST_UNIT_OPERAND: assert (!(opa == N'(1)) || (product == {{N{1'b0}}, opb})) else $error("unit operand gave %0h", product); // R4
    end

endmodule

// File: tb/tb_wallace_rc_mult.sv
`timescale 1ns/1ps
module tb_wallace_rc_mult;

    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] opa = '0;
    logic [N-1:0] opb = '0;
    logic [W-1:0] product;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    wallace_rc_mult #(.N(N)) dut (
        .opa    (opa),
        .opb    (opb),
        .product(product)
    );

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic [W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            if (y[i]) acc = acc + ({{N{1'b0}}, x} << i);
        end
        return acc;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%0d b=%0d got %0d expected %0d", tag, opa, opb, got, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(posedge clk);
        opa = x;
        opb = y;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 reset inputs zero", product, '0);
        rst = 1'b0;
    endtask

    task automatic t_zero_operand();
        apply('0, 8'hA7); check("R2 a zero", product, '0);
        apply(8'hFF, '0); check("R2 b zero", product, '0);
        apply('0, '0);    check("R2 both zero", product, '0);
    endtask

    task automatic t_unit_operand();
        apply(8'd1, 8'hC3); check("R4 a one", product, 16'h00C3);
        apply(8'h5E, 8'd1); check("R4 b one", product, 16'h005E);
    endtask

    task automatic t_all_ones();
        apply(8'hFF, 8'hFF); check("R3 all ones", product, 16'hFE01);
        apply(8'hFF, 8'hFE); check("R8 near max", product, 16'hFD02);
        apply(8'hC8, 8'hC8); check("R8 top bit", product, 16'd40000);
    endtask

    task automatic t_pow2();
        for (int k = 0; k < N; k++) begin
            apply(N'(1) << k, 8'hB5);
            check("R5 power of two", product, 16'h00B5 << k);
        end
    endtask

    task automatic t_commute();
        logic [W-1:0] first;
        apply(8'h9D, 8'h3A); first = product;
        apply(8'h3A, 8'h9D); check("R6 swapped", product, first);
        apply(8'hF0, 8'h0F); first = product;
        apply(8'h0F, 8'hF0); check("R6 swapped nibbles", product, first);
    endtask

    task automatic t_walking();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                apply(N'(1) << i, N'(1) << j);
                check("R7 single term", product, W'(1) << (i + j));
            end
        end
    endtask

    task automatic t_no_clock();
        @(posedge clk);
        #0.5;
        opa = 8'd13; opb = 8'd11;
        #0.5;
        check("R9 first change", product, 16'd143);
        opa = 8'd200; opb = 8'd3;
        #0.5;
        check("R9 second change", product, 16'd600);
        @(negedge clk);
    endtask

    task automatic t_exhaustive();
        for (int ai = 0; ai < (1 << N); ai++) begin
            for (int bi = 0; bi < (1 << N); bi++) begin
                apply(N'(ai), N'(bi));
                check("R1 all pairs", product, ref_mul(N'(ai), N'(bi)));
            end
        end
    endtask

    initial begin
        t_reset_state();
        t_zero_operand();
        t_unit_operand();
        t_all_ones();
        t_pow2();
        t_commute();
        t_walking();
        t_no_clock();
        t_exhaustive();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule